// File: doc/BRIEF.md
# Interprocessor Destination Resolver

This block turns an interprocessor interrupt command into the set of agents that must receive it. Software writes a 32-bit command as two words. The high word carries the 8-bit destination in bits [31:24] and is only stored. Writing the low word launches the command. On launch the block compares the stored destination, or the shorthand override, with every agent's physical ID, logical ID and format nibble. One cycle later it presents a target bitmask together with the delivery-mode and vector tags.

Two modes change the shape of the result. For lowest-priority delivery, the candidate set is reduced to its lowest-numbered member. For an INIT command with level 0 and trigger 1, no interrupt is delivered. The result is instead flagged as an arbitration-ID resynchronisation of the targets. The fabric around the block performs the actual injection, the transport and the focus arbitration.

Top module: `ipi_dest_resolver`

## Requirements
- R1: A low-word write produces `out_valid` for exactly one cycle, in the cycle after the write. In that cycle `out_vector` equals the written bits [7:0] and `out_mode` equals the written bits [10:8].
- R2: A high-word write stores bits [31:24] as the destination and raises no strobe. A launch always uses the destination stored before its own cycle. A high-word write in the same cycle as a launch takes effect only for later launches.
- R3: With shorthand bits [19:18] = 1, the mask holds only the bit at `self_idx`.
- R4: With shorthand 2, the mask holds every agent. With shorthand 3, it holds every agent except `self_idx`.
- R5: With shorthand 0 and destination-mode bit 11 = 0 (physical), destination 0xFF selects every agent.
- R6: In physical mode, any other destination selects the single lowest-numbered agent whose physical ID equals it. If no agent matches, the mask is zero and the strobe still fires.
- R7: In logical mode (bit 11 = 1), an agent with format nibble 0xF matches when destination AND its logical ID is nonzero.
- R8: In logical mode, an agent with format nibble 0x0 matches when destination[7:4] equals logical ID[7:4] and destination[3:0] AND logical ID[3:0] is nonzero. An agent with any other format nibble never matches logically.
- R9: With delivery mode 1 (lowest priority), the mask keeps only the lowest-numbered bit of the candidate set, after the shorthand has been applied.
- R10: `out_arb_sync` is 1 with the strobe exactly when delivery mode is 5 (INIT), level bit 14 is 0 and trigger bit 15 is 1. The mask then names the agents that resynchronise.
- R11: A low-word write in the strobe cycle is ignored. Outside the strobe, `out_mask` and `out_arb_sync` are 0, including after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lo_wr | input | 1 | Low command word write (launch) |
| hi_wr | input | 1 | High command word write (store destination) |
| wr_data | input | 32 | Write data for either word |
| self_idx | input | IW | Index of the sending agent |
| agent_pid | input | NAG*8 | Physical ID per agent, agent i at [8i+7:8i] |
| agent_lid | input | NAG*8 | Logical ID per agent |
| agent_fmt | input | NAG*4 | Destination-format nibble per agent |
| out_valid | output | 1 | Single-cycle result strobe |
| out_mask | output | NAG | Target agents |
| out_mode | output | 3 | Delivery-mode tag |
| out_vector | output | 8 | Vector tag |
| out_arb_sync | output | 1 | Result is an arbitration-ID resync, not a delivery |

## Verification
Two pairs of events can fall in the same cycle. A high-word write can coincide with a launch. A new launch can arrive in the cycle of the previous strobe. The bench provokes the first case by writing destination 0x40 together with a launch, after 0x47 has been stored. It expects agent 7 to be targeted, and agent 0 only on the following launch. It provokes the second case by holding the low-word write for three cycles and expects strobes in the first and third result cycles only. A behavioural model runs alongside and judges every cycle, and directed checks pin the hand-computed masks.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    typedef enum logic [1:0] {
        SH_DEST   = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    localparam logic [2:0] DM_LOWPRI   = 3'd1;
    localparam logic [2:0] DM_INIT     = 3'd5;
    localparam logic [7:0] BCAST_ID    = 8'hFF;
    localparam logic [3:0] FMT_FLAT    = 4'hF;
    localparam logic [3:0] FMT_CLUSTER = 4'h0;

    // command field positions
    localparam int F_VEC_LSB  = 0;
    localparam int F_DM_LSB   = 8;
    localparam int F_LOGICAL  = 11;
    localparam int F_LEVEL    = 14;
    localparam int F_TRIGGER  = 15;
    localparam int F_SH_LSB   = 18;
    localparam int F_DEST_LSB = 24;
endpackage

// File: rtl/ipi_agent_match.sv
module ipi_agent_match
    import ipi_pkg::*;
#(
    parameter int IDX = 0,
    parameter int IW  = 5
) (
    input  logic [7:0]    dest,
    input  logic          logical,
    input  shorthand_e    sh,
    input  logic [IW-1:0] self_idx,
    input  logic [7:0]    pid,
    input  logic [7:0]    lid,
    input  logic [3:0]    fmt,
    output logic          hit
);
    logic is_self;
    logic dest_hit;

    always_comb begin
        is_self = (self_idx == IW'(IDX));
        if (!logical) begin
            dest_hit = (dest == BCAST_ID) || (pid == dest);
        end else if (fmt == FMT_FLAT) begin
            dest_hit = |(dest & lid);
        end else if (fmt == FMT_CLUSTER) begin
            dest_hit = (dest[7:4] == lid[7:4]) && (|(dest[3:0] & lid[3:0]));
        end else begin
            dest_hit = 1'b0;
        end
        case (sh)
            SH_DEST: hit = dest_hit;
            SH_SELF: hit = is_self;
            SH_ALL:  hit = 1'b1;
            default: hit = !is_self;
        endcase
    end
endmodule

// File: rtl/ipi_first.sv
module ipi_first #(
    parameter int N = 32
) (
    input  logic [N-1:0] in_mask,
    output logic [N-1:0] out_mask
);
    logic found;

    always_comb begin
        out_mask = '0;
        found    = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (in_mask[i] && !found) begin
                out_mask[i] = 1'b1;
                found       = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ipi_dest_resolver.sv
module ipi_dest_resolver
    import ipi_pkg::*;
#(
    parameter int NAG = 32,
    localparam int IW = (NAG > 1) ? $clog2(NAG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic [31:0]       wr_data,
    input  logic [IW-1:0]     self_idx,
    input  logic [NAG*8-1:0]  agent_pid,
    input  logic [NAG*8-1:0]  agent_lid,
    input  logic [NAG*4-1:0]  agent_fmt,
    output logic              out_valid,
    output logic [NAG-1:0]    out_mask,
    output logic [2:0]        out_mode,
    output logic [7:0]        out_vector,
    output logic              out_arb_sync
);
    typedef struct packed {
        logic [7:0]     dest;
        logic           valid;
        logic [NAG-1:0] mask;
        logic [2:0]     mode;
        logic [7:0]     vector;
        logic           arb_sync;
    } state_t;

    state_t st_q, st_d;

    // launch-word decode
    logic       logical;
    logic [2:0] dmode;
    shorthand_e sh;
    logic       accept;
    logic       pick_first;
    logic [NAG-1:0] cand_mask;
    logic [NAG-1:0] first_mask;

    assign logical = wr_data[F_LOGICAL];
    assign dmode   = wr_data[F_DM_LSB +: 3];
    assign sh      = shorthand_e'(wr_data[F_SH_LSB +: 2]);
    assign accept  = lo_wr && !st_q.valid;

    wire unused_wr = ^{wr_data[23:20], wr_data[17:16], wr_data[13:12]};

    for (genvar g = 0; g < NAG; g++) begin : g_agent
        ipi_agent_match #(.IDX(g), .IW(IW)) u_match (
            .dest     (st_q.dest),
            .logical  (logical),
            .sh       (sh),
            .self_idx (self_idx),
            .pid      (agent_pid[g*8 +: 8]),
            .lid      (agent_lid[g*8 +: 8]),
            .fmt      (agent_fmt[g*4 +: 4]),
            .hit      (cand_mask[g])
        );
    end

    ipi_first #(.N(NAG)) u_first (
        .in_mask  (cand_mask),
        .out_mask (first_mask)
    );

    // single winner for lowest priority and for physical unicast
    assign pick_first = (dmode == DM_LOWPRI)
                     || ((sh == SH_DEST) && !logical && (st_q.dest != BCAST_ID));

    always_comb begin
        st_d          = st_q;
        st_d.valid    = 1'b0;
        st_d.mask     = '0;
        st_d.arb_sync = 1'b0;
        if (hi_wr) begin
            st_d.dest = wr_data[F_DEST_LSB +: 8];
        end
        if (accept) begin
            st_d.valid    = 1'b1;
            st_d.mask     = pick_first ? first_mask : cand_mask;
            st_d.mode     = dmode;
            st_d.vector   = wr_data[F_VEC_LSB +: 8];
            st_d.arb_sync = (dmode == DM_INIT) && !wr_data[F_LEVEL]
                          && wr_data[F_TRIGGER];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid    = st_q.valid;
    assign out_mask     = st_q.mask;
    assign out_mode     = st_q.mode;
    assign out_vector   = st_q.vector;
    assign out_arb_sync = st_q.arb_sync;
endmodule

// File: rtl/ipi_dest_resolver_chk.sv
module ipi_dest_resolver_chk #(
    parameter int NAG = 32,
    localparam int IW = (NAG > 1) ? $clog2(NAG) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           lo_wr,
    input logic [31:0]    wr_data,
    input logic [IW-1:0]  self_idx,
    input logic           out_valid,
    input logic [NAG-1:0] out_mask,
    input logic [2:0]     out_mode,
    input logic           out_arb_sync
);
    AST_STROBE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr && !out_valid) |=> out_valid); // R1
    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R11
    AST_IDLE_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_mask == '0)); // R11
    AST_LOWPRI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mode == 3'd1) |-> $onehot0(out_mask)); // R9
    AST_SELF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(wr_data[19:18]) == 2'd1)
            |-> (out_mask == (NAG'(1) << $past(self_idx)))); // R3
    AST_OTHERS_SKIP_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(wr_data[19:18]) == 2'd3)
            |-> !out_mask[$past(self_idx)]); // R4
    AST_ARB_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_arb_sync |-> (out_valid && out_mode == 3'd5)); // R10
endmodule

bind ipi_dest_resolver ipi_dest_resolver_chk #(.NAG(NAG)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lo_wr        (lo_wr),
    .wr_data      (wr_data),
    .self_idx     (self_idx),
    .out_valid    (out_valid),
    .out_mask     (out_mask),
    .out_mode     (out_mode),
    .out_arb_sync (out_arb_sync)
);

// File: tb/tb_ipi_dest_resolver.sv
module tb_ipi_dest_resolver;
    localparam int NAG = 32;
    localparam int IW  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lo_wr = 1'b0;
    logic hi_wr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [IW-1:0] self_idx = 5'd3;
    logic [NAG*8-1:0] agent_pid;
    logic [NAG*8-1:0] agent_lid;
    logic [NAG*4-1:0] agent_fmt;
    logic out_valid, out_arb_sync;
    logic [NAG-1:0] out_mask;
    logic [2:0] out_mode;
    logic [7:0] out_vector;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    string cur_req = "R11";

    always #5 clk = ~clk;

    ipi_dest_resolver #(.NAG(NAG)) dut (
        .clk(clk), .rst_n(rst_n), .lo_wr(lo_wr), .hi_wr(hi_wr),
        .wr_data(wr_data), .self_idx(self_idx), .agent_pid(agent_pid),
        .agent_lid(agent_lid), .agent_fmt(agent_fmt), .out_valid(out_valid),
        .out_mask(out_mask), .out_mode(out_mode), .out_vector(out_vector),
        .out_arb_sync(out_arb_sync)
    );

    // behavioural reference
    function automatic logic [31:0] ref_targets(input logic [31:0] lo,
                                                input logic [7:0] dest,
                                                input int self_i);
        logic [31:0] m = '0;
        bit taken = 0;
        int sh = int'(lo[19:18]);
        for (int i = 0; i < NAG; i++) begin
            logic [7:0] lid = agent_lid[i*8 +: 8];
            logic [3:0] fmt = agent_fmt[i*4 +: 4];
            if (sh == 1) m[i] = (i == self_i);
            else if (sh == 2) m[i] = 1'b1;
            else if (sh == 3) m[i] = (i != self_i);
            else if (!lo[11]) begin
                if (dest == 8'hFF) m[i] = 1'b1;
                else if (agent_pid[i*8 +: 8] == dest && !taken) begin
                    m[i] = 1'b1;
                    taken = 1;
                end
            end else if (fmt == 4'hF) m[i] = (dest & lid) != 0;
            else if (fmt == 4'h0)
                m[i] = (dest[7:4] == lid[7:4]) && ((dest[3:0] & lid[3:0]) != 0);
        end
        if (lo[10:8] == 3'd1) begin
            for (int i = 0; i < NAG; i++) begin
                if (m[i]) begin
                    m = 32'd1 << i;
                    break;
                end
            end
        end
        return m;
    endfunction

    logic [7:0]  m_dest;
    logic        m_valid, m_arb;
    logic [31:0] m_mask;
    logic [2:0]  m_mode;
    logic [7:0]  m_vec;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dest <= 0; m_valid <= 0; m_mask <= 0; m_arb <= 0; m_mode <= 0; m_vec <= 0;
        end else begin
            if (hi_wr) m_dest <= wr_data[31:24];
            if (lo_wr && !m_valid) begin
                m_valid <= 1'b1;
                m_mask  <= ref_targets(wr_data, m_dest, int'(self_idx));
                m_arb   <= (wr_data[10:8] == 3'd5) && !wr_data[14] && wr_data[15];
                m_mode  <= wr_data[10:8];
                m_vec   <= wr_data[7:0];
            end else begin
                m_valid <= 1'b0; m_mask <= '0; m_arb <= 1'b0;
            end
        end
    end

    // per-cycle comparison with the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (out_valid !== m_valid || out_mask !== m_mask || out_arb_sync !== m_arb ||
                (m_valid && (out_mode !== m_mode || out_vector !== m_vec))) begin
                fails++;
                $display("FAIL %s model: got v=%0b mask=%h arb=%0b mode=%0d vec=%h exp v=%0b mask=%h arb=%0b mode=%0d vec=%h",
                         cur_req, out_valid, out_mask, out_arb_sync, out_mode, out_vector,
                         m_valid, m_mask, m_arb, m_mode, m_vec);
            end
        end
    end

    function automatic logic [31:0] mk_lo(input logic [7:0] vec, input logic [2:0] dm,
                                          input logic lg, input logic lvl,
                                          input logic trg, input logic [1:0] sh);
        return {12'b0, sh, 2'b0, trg, lvl, 2'b0, lg, dm, vec};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic set_hi(input logic [7:0] dest);
        @(negedge clk);
        hi_wr = 1'b1; lo_wr = 1'b0; wr_data = {dest, 24'h0};
        @(negedge clk);
        hi_wr = 1'b0;
    endtask

    task automatic launch(input logic [31:0] lo, input string tag,
                          input logic [31:0] exp, input logic arb_exp);
        @(negedge clk);
        cur_req = tag;
        lo_wr = 1'b1; wr_data = lo;
        @(negedge clk);
        lo_wr = 1'b0;
        check({tag, " strobe"}, {31'b0, out_valid}, 32'd1);
        check({tag, " mask"}, out_mask, exp);
        check({tag, " arb"}, {31'b0, out_arb_sync}, {31'b0, arb_exp});
        check({tag, " vector/mode R1"}, {21'b0, out_mode, out_vector}, {21'b0, lo[10:8], lo[7:0]});
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < NAG; i++) begin
            agent_pid[i*8 +: 8] = 8'h40 + 8'(i);
            if (i < 16) begin
                agent_fmt[i*4 +: 4] = 4'hF;
                agent_lid[i*8 +: 8] = 8'd1 << (i % 8);
            end else if (i < 28) begin
                agent_fmt[i*4 +: 4] = 4'h0;
                agent_lid[i*8 +: 8] = {4'((i - 16) / 4), 4'd1 << ((i - 16) % 4)};
            end else begin
                agent_fmt[i*4 +: 4] = 4'h5;
                agent_lid[i*8 +: 8] = 8'hFF;
            end
        end
        agent_pid[5*8 +: 8] = 8'h33;
        agent_pid[9*8 +: 8] = 8'h33;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset valid", {31'b0, out_valid}, 32'd0);
        check("R11 reset mask", out_mask, 32'd0);

        set_hi(8'h47);
        check("R2 hi write no strobe", {31'b0, out_valid}, 32'd0);
        launch(mk_lo(8'h21, 3'd0, 0, 1, 0, 2'd0), "R6 unicast", 32'h0000_0080, 0);
        set_hi(8'h33);
        launch(mk_lo(8'h22, 3'd0, 0, 1, 0, 2'd0), "R6 duplicate id", 32'h0000_0020, 0);
        set_hi(8'h99);
        launch(mk_lo(8'h23, 3'd4, 0, 1, 0, 2'd0), "R6 no match", 32'h0, 0);
        set_hi(8'hFF);
        launch(mk_lo(8'h24, 3'd0, 0, 1, 0, 2'd0), "R5 broadcast", 32'hFFFF_FFFF, 0);
        set_hi(8'h05);
        launch(mk_lo(8'h25, 3'd0, 1, 1, 0, 2'd0), "R7 flat+cluster", 32'h0005_0505, 0);
        set_hi(8'h2C);
        launch(mk_lo(8'h26, 3'd0, 1, 1, 0, 2'd0), "R8 cluster", 32'h0C00_2C2C, 0);
        launch(mk_lo(8'h27, 3'd1, 1, 1, 0, 2'd0), "R9 lowpri", 32'h0000_0004, 0);
        launch(mk_lo(8'h28, 3'd1, 0, 1, 0, 2'd3), "R9 lowpri others", 32'h0000_0001, 0);
        launch(mk_lo(8'h29, 3'd0, 0, 1, 0, 2'd1), "R3 self", 32'h0000_0008, 0);
        launch(mk_lo(8'h2A, 3'd0, 0, 1, 0, 2'd2), "R4 all", 32'hFFFF_FFFF, 0);
        launch(mk_lo(8'h2B, 3'd0, 0, 1, 0, 2'd3), "R4 others", 32'hFFFF_FFF7, 0);
        launch(mk_lo(8'h00, 3'd5, 0, 0, 1, 2'd2), "R10 init deassert", 32'hFFFF_FFFF, 1);
        launch(mk_lo(8'h00, 3'd5, 0, 1, 1, 2'd2), "R10 init asserted", 32'hFFFF_FFFF, 0);

        // R2: destination written together with a launch
        set_hi(8'h47);
        @(negedge clk);
        cur_req = "R2 same-cycle";
        hi_wr = 1'b1; lo_wr = 1'b1;
        wr_data = {8'h40, 24'h0} | mk_lo(8'h30, 3'd0, 0, 1, 0, 2'd0);
        @(negedge clk);
        hi_wr = 1'b0; lo_wr = 1'b0;
        check("R2 old dest used", out_mask, 32'h0000_0080);
        @(negedge clk);
        launch(mk_lo(8'h31, 3'd0, 0, 1, 0, 2'd0), "R2 new dest", 32'h0000_0001, 0);

        // R11: launch held for three cycles
        @(negedge clk);
        cur_req = "R11 busy";
        lo_wr = 1'b1; wr_data = mk_lo(8'h40, 3'd0, 0, 1, 0, 2'd1);
        @(negedge clk);
        check("R11 first strobe", {31'b0, out_valid}, 32'd1);
        @(negedge clk);
        check("R11 ignored write", {31'b0, out_valid}, 32'd0);
        check("R11 idle mask", out_mask, 32'd0);
        @(negedge clk);
        lo_wr = 1'b0;
        check("R11 third write accepted", {31'b0, out_valid}, 32'd1);
        repeat (3) @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end
endmodule